// File: doc/BRIEF.md
# Dual-Bank Echo Balance Coefficient Store

This block supplies the coefficients of a 64-tap echo balance filter. The host loads a fixed bank of default coefficients through a byte-wide register port, and these values serve as a static balance network. A separate adapter port writes correction terms into an adaptive bank. For every tap the filter datapath asks for, the block returns one effective 16-bit coefficient: the fixed value plus the adaptive correction, limited to the signed 16-bit range. The correction is applied only to taps inside a leading window whose length the host selects.

A third, alternate bank can be loaded by the host. When data-call mode is selected, the alternate coefficient is returned in place of the normal sum. The adaptive bank is not visible to the host. It is cleared at reset and whenever the host changes the window length. The adaptation process only ever touches the adaptive bank.

Top module: `echo_coef_store`

## Requirements
- R1: After reset, `coef_valid` is 0, `host_rdata` is 0, the control register is 0, and every bank holds zero, so a request for any tap returns 0.
- R2: Host address map, with read data appearing on `host_rdata` one cycle after `host_addr` is presented. Address 2t holds the high byte of fixed tap t and address 2t+1 holds its low byte (0..127). Addresses 128+2t and 129+2t hold the alternate tap t in the same way. Address 256 is the control register: bits [2:0] are the window code, bit 3 selects data-call mode, and bits [7:4] read as 0. Every other address reads 0 and ignores writes.
- R3: A request pulse `flt_req` with `flt_tap` produces `coef_valid` high exactly one cycle later, with `coef_out` holding that tap's coefficient. With no request, `coef_valid` is low in the next cycle.
- R4: The window codes are 1 = first 8 taps, 2 = first 16, 3 = first 32 and 4 = all 64. Codes 0, 5, 6 and 7 disable adaptation, so outputs equal the fixed bank.
- R5: Outside data-call mode, the output for tap t is fixed[t] + adaptive[t] when t is less than the window length, and fixed[t] otherwise. Adapter writes to taps outside the window, or made while adaptation is disabled, are dropped.
- R6: The sum saturates to the range 0x8000..0x7FFF and never wraps.
- R7: A control write that changes the decoded window length clears the whole adaptive bank. A control write that keeps the same length, including one that only toggles data-call mode, keeps the bank.
- R8: Adapter writes never alter the fixed bank as read back over the host port.
- R9: With data-call mode set, `coef_out` is the alternate-bank coefficient for the tap, and no adaptive correction is added.
- R10: Same-cycle ordering. A length-changing control write and an adapter write in the same cycle leave the adaptive bank cleared. A request in the same cycle as a host write to that tap returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 9 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after the address |
| adp_we | input | 1 | Adapter correction write strobe |
| adp_tap | input | 6 | Tap index of the correction |
| adp_corr | input | 16 | Signed correction value |
| flt_req | input | 1 | Filter coefficient request |
| flt_tap | input | 6 | Requested tap index |
| coef_valid | output | 1 | Effective coefficient valid |
| coef_out | output | 16 | Effective signed coefficient |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a host control write that changes the window length and an adapter correction write. The second pair is a host write to a fixed coefficient byte and a filter request for that same tap. The bench drives each pair on one clock edge. It then judges the result at the coefficient output: in the first case the output must equal the fixed value alone, with the correction lost; in the second case the first request must return the pre-write coefficient and a following request must return the new one. Random stimulus mixes host, adapter, control and request traffic against a bench model that includes saturation and window decoding.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

  // window length codes held in the control register
  localparam logic [2:0] WIN_OFF = 3'd0;
  localparam logic [2:0] WIN_8TH = 3'd1;
  localparam logic [2:0] WIN_QTR = 3'd2;
  localparam logic [2:0] WIN_HLF = 3'd3;
  localparam logic [2:0] WIN_ALL = 3'd4;

  typedef struct packed {
    logic       dcall;
    logic [2:0] win;
  } ctrl_t;

endpackage

// File: rtl/ecs_host_bank.sv
module ecs_host_bank
  import ecs_pkg::*;
#(
  parameter int TAPS = 64,
  parameter int CW   = 16,
  parameter int TW   = $clog2(TAPS),
  parameter int HAW  = TW + 3,
  parameter int HW   = CW / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [HAW-1:0]  host_addr,
  input  logic [HW-1:0]   host_wdata,
  output logic [HW-1:0]   host_rdata,
  input  logic [TW-1:0]   rd_tap,
  output logic [CW-1:0]   fix_coef,
  output logic [CW-1:0]   alt_coef,
  output logic [TW:0]     win_len,
  output logic            dcall,
  output logic            win_clr
);

  localparam int NB = 2 * TAPS;
  localparam int BW = TW + 1;
  localparam int LW = TW + 1;

  logic [NB-1:0][HW-1:0] fix_q, fix_d;
  logic [NB-1:0][HW-1:0] alt_q, alt_d;
  ctrl_t                 ctrl_q, ctrl_d;
  logic [HW-1:0]         rdata_q, rdata_d;

  logic          is_ctrl, is_fix, is_alt;
  logic [BW-1:0] byte_ix;
  logic          fix_en, alt_en, ctrl_en;

  function automatic logic [LW-1:0] len_of(input logic [2:0] code);
    case (code)
      WIN_8TH: len_of = LW'(TAPS / 8);
      WIN_QTR: len_of = LW'(TAPS / 4);
      WIN_HLF: len_of = LW'(TAPS / 2);
      WIN_ALL: len_of = LW'(TAPS);
      default: len_of = '0;
    endcase
  endfunction

  // address decode
  always_comb begin
    is_ctrl = host_addr[HAW-1] && (host_addr[HAW-2:0] == '0);
    is_fix  = !host_addr[HAW-1] && !host_addr[HAW-2];
    is_alt  = !host_addr[HAW-1] &&  host_addr[HAW-2];
    byte_ix = host_addr[BW-1:0];
    fix_en  = host_we && is_fix;
    alt_en  = host_we && is_alt;
    ctrl_en = host_we && is_ctrl;
  end

  // next state
  always_comb begin
    fix_d  = fix_q;
    alt_d  = alt_q;
    ctrl_d = ctrl_q;
    if (fix_en)  fix_d[byte_ix] = host_wdata;
    if (alt_en)  alt_d[byte_ix] = host_wdata;
    if (ctrl_en) ctrl_d = ctrl_t'(host_wdata[3:0]);
  end

  always_comb begin
    rdata_d = '0;
    if (is_fix)       rdata_d = fix_q[byte_ix];
    else if (is_alt)  rdata_d = alt_q[byte_ix];
    else if (is_ctrl) rdata_d = {{(HW-4){1'b0}}, ctrl_q};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_q   <= '0;
      alt_q   <= '0;
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (fix_en)  fix_q  <= fix_d;
      if (alt_en)  alt_q  <= alt_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
      rdata_q <= rdata_d;
    end
  end

  // outputs toward the datapath
  always_comb begin
    win_len    = len_of(ctrl_q.win);
    dcall      = ctrl_q.dcall;
    win_clr    = ctrl_en && (len_of(host_wdata[2:0]) != win_len);
    fix_coef   = {fix_q[{rd_tap, 1'b0}], fix_q[{rd_tap, 1'b1}]};
    alt_coef   = {alt_q[{rd_tap, 1'b0}], alt_q[{rd_tap, 1'b1}]};
    host_rdata = rdata_q;
  end

  // unmapped addresses read back as zero
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr[HAW-1] && (host_addr[HAW-2:0] != '0)) |=> (host_rdata == '0));

  // only a host write into the fixed range may change the fixed bank
  p_fixed_host_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && !host_addr[HAW-1] && !host_addr[HAW-2]) |=> $stable(fix_q));

endmodule

// File: rtl/ecs_adapt_bank.sv
module ecs_adapt_bank #(
  parameter int TAPS = 64,
  parameter int CW   = 16,
  parameter int TW   = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [TW:0]   win_len,
  input  logic          adp_we,
  input  logic [TW-1:0] adp_tap,
  input  logic [CW-1:0] adp_corr,
  input  logic [TW-1:0] rd_tap,
  output logic [CW-1:0] adj
);

  logic [TAPS-1:0][CW-1:0] mem_q, mem_d;
  logic                    wr_ok;
  logic                    mem_en;

  always_comb begin
    wr_ok  = adp_we && !clr && ({1'b0, adp_tap} < win_len);
    mem_en = clr || wr_ok;
    mem_d  = mem_q;
    if (clr)        mem_d = '0;
    else if (wr_ok) mem_d[adp_tap] = adp_corr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_q <= '0;
    else if (mem_en) mem_q <= mem_d;
  end

  always_comb begin
    adj = ({1'b0, rd_tap} < win_len) ? mem_q[rd_tap] : '0;
  end

  // a window length change leaves no correction behind
  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mem_q == '0));

  // out-of-window adapter writes leave the bank untouched
  p_outside_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adp_we && !clr && ({1'b0, adp_tap} >= win_len)) |=> $stable(mem_q));

endmodule

// File: rtl/ecs_coef_sum.sv
module ecs_coef_sum #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          dcall,
  input  logic [CW-1:0] fix_coef,
  input  logic [CW-1:0] adj,
  input  logic [CW-1:0] alt_coef,
  output logic          coef_valid,
  output logic [CW-1:0] coef_out
);

  localparam logic [CW-1:0] SAT_MAX = {1'b0, {(CW-1){1'b1}}};
  localparam logic [CW-1:0] SAT_MIN = {1'b1, {(CW-1){1'b0}}};

  logic [CW:0]   wide;
  logic [CW-1:0] sat;
  logic [CW-1:0] coef_d, coef_q;
  logic          valid_q;

  always_comb begin
    wide = {fix_coef[CW-1], fix_coef} + {adj[CW-1], adj};
    if (wide[CW] != wide[CW-1]) sat = wide[CW] ? SAT_MIN : SAT_MAX;
    else                        sat = wide[CW-1:0];
    coef_d = dcall ? alt_coef : sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      coef_q  <= '0;
    end else begin
      valid_q <= req;
      if (req) coef_q <= coef_d;
    end
  end

  assign coef_valid = valid_q;
  assign coef_out   = coef_q;

  p_valid_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> coef_valid);
  p_no_valid_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !coef_valid);

  // two non-negative terms never come out negative
  p_no_pos_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !dcall && !fix_coef[CW-1] && !adj[CW-1]) |=> !coef_out[CW-1]);
  // two negative terms never come out non-negative
  p_no_neg_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !dcall && fix_coef[CW-1] && adj[CW-1]) |=> coef_out[CW-1]);

  p_alt_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && dcall) |=> (coef_out == $past(alt_coef)));

endmodule

// File: rtl/echo_coef_store.sv
module echo_coef_store #(
  parameter int TAPS = 64,
  parameter int CW   = 16,
  localparam int TW  = $clog2(TAPS),
  localparam int HAW = TW + 3,
  localparam int HW  = CW / 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_we,
  input  logic [HAW-1:0] host_addr,
  input  logic [HW-1:0]  host_wdata,
  output logic [HW-1:0]  host_rdata,
  input  logic           adp_we,
  input  logic [TW-1:0]  adp_tap,
  input  logic [CW-1:0]  adp_corr,
  input  logic           flt_req,
  input  logic [TW-1:0]  flt_tap,
  output logic           coef_valid,
  output logic [CW-1:0]  coef_out
);

  logic          rst_meta, rst_sync;
  logic [CW-1:0] fix_coef, alt_coef, adj;
  logic [TW:0]   win_len;
  logic          dcall, win_clr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  ecs_host_bank #(.TAPS(TAPS), .CW(CW), .TW(TW), .HAW(HAW), .HW(HW)) u_host (
    .clk        (clk),
    .rst_n      (rst_sync),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .rd_tap     (flt_tap),
    .fix_coef   (fix_coef),
    .alt_coef   (alt_coef),
    .win_len    (win_len),
    .dcall      (dcall),
    .win_clr    (win_clr)
  );

  ecs_adapt_bank #(.TAPS(TAPS), .CW(CW), .TW(TW)) u_adapt (
    .clk      (clk),
    .rst_n    (rst_sync),
    .clr      (win_clr),
    .win_len  (win_len),
    .adp_we   (adp_we),
    .adp_tap  (adp_tap),
    .adp_corr (adp_corr),
    .rd_tap   (flt_tap),
    .adj      (adj)
  );

  ecs_coef_sum #(.CW(CW)) u_sum (
    .clk        (clk),
    .rst_n      (rst_sync),
    .req        (flt_req),
    .dcall      (dcall),
    .fix_coef   (fix_coef),
    .adj        (adj),
    .alt_coef   (alt_coef),
    .coef_valid (coef_valid),
    .coef_out   (coef_out)
  );

endmodule

// File: tb/test_echo_coef_store.sv
module test_echo_coef_store;

  localparam int TAPS = 64;
  localparam int CW   = 16;
  localparam int TW   = 6;
  localparam int HAW  = 9;
  localparam int HW   = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           host_we;
  logic [HAW-1:0] host_addr;
  logic [HW-1:0]  host_wdata;
  logic [HW-1:0]  host_rdata;
  logic           adp_we;
  logic [TW-1:0]  adp_tap;
  logic [CW-1:0]  adp_corr;
  logic           flt_req;
  logic [TW-1:0]  flt_tap;
  logic           coef_valid;
  logic [CW-1:0]  coef_out;

  always #4 clk = ~clk;

  echo_coef_store #(.TAPS(TAPS), .CW(CW)) i_echo_coef_store (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .adp_we(adp_we), .adp_tap(adp_tap), .adp_corr(adp_corr),
    .flt_req(flt_req), .flt_tap(flt_tap),
    .coef_valid(coef_valid), .coef_out(coef_out)
  );

  // bench model
  logic [CW-1:0] m_fix [TAPS];
  logic [CW-1:0] m_alt [TAPS];
  logic [CW-1:0] m_adp [TAPS];
  logic [3:0]    m_ctrl;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  function automatic int wlen(input logic [2:0] c);
    case (c)
      3'd1: return 8;
      3'd2: return 16;
      3'd3: return 32;
      3'd4: return 64;
      default: return 0;
    endcase
  endfunction

  function automatic logic [CW-1:0] exp_coef(input int t);
    int s;
    if (m_ctrl[3]) return m_alt[t];
    s = int'($signed(m_fix[t]));
    if (t < wlen(m_ctrl[2:0])) s = s + int'($signed(m_adp[t]));
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return CW'(s);
  endfunction

  function automatic logic [HW-1:0] exp_rd(input int a);
    if (a < 128) return (a % 2 == 0) ? m_fix[a/2][15:8] : m_fix[a/2][7:0];
    if (a < 256) return (a % 2 == 0) ? m_alt[(a-128)/2][15:8] : m_alt[(a-128)/2][7:0];
    if (a == 256) return {4'b0, m_ctrl};
    return '0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mdl_host(input int a, input logic [7:0] d);
    if (a < 128) begin
      if (a % 2 == 0) m_fix[a/2][15:8] = d; else m_fix[a/2][7:0] = d;
    end else if (a < 256) begin
      if (a % 2 == 0) m_alt[(a-128)/2][15:8] = d; else m_alt[(a-128)/2][7:0] = d;
    end else if (a == 256) begin
      if (wlen(d[2:0]) != wlen(m_ctrl[2:0]))
        for (int i = 0; i < TAPS; i++) m_adp[i] = '0;
      m_ctrl = d[3:0];
    end
  endtask

  task automatic hwr(input int a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = HAW'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    mdl_host(a, d);
  endtask

  task automatic hrd(input int a, input string req);
    @(negedge clk);
    host_addr = HAW'(a);
    @(negedge clk);
    check(req, 32'(host_rdata), 32'(exp_rd(a)));
  endtask

  task automatic set_fix(input int t, input logic [15:0] v);
    hwr(2*t, v[15:8]);
    hwr(2*t+1, v[7:0]);
  endtask

  task automatic set_alt(input int t, input logic [15:0] v);
    hwr(128+2*t, v[15:8]);
    hwr(129+2*t, v[7:0]);
  endtask

  task automatic awr(input int t, input logic [15:0] v);
    @(negedge clk);
    adp_we = 1'b1; adp_tap = TW'(t); adp_corr = v;
    @(negedge clk);
    adp_we = 1'b0;
    if (t < wlen(m_ctrl[2:0])) m_adp[t] = v;
  endtask

  task automatic rq(input int t, input string req);
    logic [CW-1:0] e;
    @(negedge clk);
    flt_req = 1'b1; flt_tap = TW'(t);
    e = exp_coef(t);
    @(negedge clk);
    flt_req = 1'b0;
    check({req, " valid"}, 32'(coef_valid), 32'd1);
    check(req, 32'(coef_out), 32'(e));
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    logic [CW-1:0] e;
    host_we = 0; host_addr = '0; host_wdata = '0;
    adp_we = 0; adp_tap = '0; adp_corr = '0;
    flt_req = 0; flt_tap = '0;
    for (int i = 0; i < TAPS; i++) begin m_fix[i] = '0; m_alt[i] = '0; m_adp[i] = '0; end
    m_ctrl = '0;
    rst_n = 1'b0;
    sd = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 valid", 32'(coef_valid), 32'd0);
    check("R1 rdata", 32'(host_rdata), 32'd0);
    hrd(256, "R1 ctrl");
    rq(5, "R1 coef");

    // R2 address map
    set_fix(3, 16'h1234);
    hrd(6, "R2 fixed high");
    hrd(7, "R2 fixed low");
    set_alt(3, 16'hBEEF);
    hrd(134, "R2 alt high");
    hwr(300, 8'h5A);
    hrd(300, "R2 unmapped");
    hwr(256, 8'hF1);
    hrd(256, "R2 ctrl readback");

    // R4/R5 eight-tap window
    awr(3, 16'h0010);
    set_fix(10, 16'h0200);
    awr(10, 16'h0005);
    rq(3, "R5 in window");
    rq(10, "R5 outside window");
    // reserved code behaves as disabled
    hwr(256, 8'h05);
    awr(3, 16'h0033);
    rq(3, "R4 reserved disables");

    // R7 same length keeps, change clears
    hwr(256, 8'h04);
    set_fix(40, 16'h0100);
    awr(40, 16'h0007);
    hwr(256, 8'h04);
    rq(40, "R7 same length keeps");
    hwr(256, 8'h03);
    rq(40, "R7 change clears");
    hwr(256, 8'h04);

    // R6 saturation
    set_fix(0, 16'h7F00); awr(0, 16'h1000);
    rq(0, "R6 positive clamp");
    set_fix(1, 16'h8000); awr(1, 16'hFFFF);
    rq(1, "R6 negative clamp");
    set_fix(2, 16'h7FFF); awr(2, 16'h8000);
    rq(2, "R6 no clamp");

    // R8 fixed bank untouched by adapter
    hrd(0, "R8 fixed high");
    hrd(1, "R8 fixed low");

    // R9 data-call mode
    set_alt(0, 16'hA5C3);
    hwr(256, 8'h0C);
    rq(0, "R9 alternate");
    hwr(256, 8'h04);
    rq(0, "R9 correction kept");

    // R10 control change and adapter write together
    @(negedge clk);
    host_we = 1; host_addr = HAW'(256); host_wdata = 8'h03;
    adp_we = 1; adp_tap = TW'(2); adp_corr = 16'h0100;
    @(negedge clk);
    host_we = 0; adp_we = 0;
    mdl_host(256, 8'h03);
    rq(2, "R10 clear wins");

    // R10 host write and request on the same tap
    @(negedge clk);
    e = exp_coef(2);
    host_we = 1; host_addr = HAW'(4); host_wdata = 8'h11;
    flt_req = 1; flt_tap = TW'(2);
    @(negedge clk);
    host_we = 0; flt_req = 0;
    mdl_host(4, 8'h11);
    check("R10 old value", 32'(coef_out), 32'(e));
    rq(2, "R10 new value");

    // R3 valid drops when idle
    @(negedge clk);
    check("R3 idle", 32'(coef_valid), 32'd0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned op;
      op = $urandom % 10;
      if (op < 3)      hwr($urandom % 256, 8'($urandom));
      else if (op < 5) awr($urandom % TAPS, 16'($urandom));
      else if (op < 6) hwr(256, 8'($urandom % 16));
      else if (op < 9) rq($urandom % TAPS, "R5 random");
      else             hrd($urandom % 300, "R2 random");
    end

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule